// File: doc/BRIEF.md
# Event Performance Monitor Unit

This block counts what happens on a chip so that software can profile it. It holds one cycle counter and four programmable 32-bit event counters. Each event counter is linked to one line of an event pulse vector, and it counts the cycles in which that line is high. The cycle counter counts clock cycles. An optional divide-by-64 prescaler stretches its range. All counters can be preloaded. Software usually loads the two's complement of a sample period, so the counter wraps after exactly that many events. A wrap sets a sticky overflow flag. A level interrupt is raised while any flag whose interrupt enable is set is asserted.

Software reaches the block through a single-cycle register port. A write takes effect at the clock edge on which `reg_req` and `reg_we` are both high. A read returns data combinationally in the same cycle as `reg_req`. The port never stalls, so it has no back-pressure. Counters are switched on and off through a pair of set-style and clear-style registers. The event counters are reached indirectly through a select register.

Top module: `perf_monitor`

## Requirements
- R1: After reset, every register reads as 0 and `irq` is low.
- R2: The control register sits at word address 0. Bit 0 is the global enable and bit 3 selects divide-by-64 for the cycle counter. Bits 4 and 5 are plain stored bits. Bits 1 and 2 are one-shot strobes that always read as 0. All other bits read as 0, so writing all ones reads back 0x39.
- R3: Word address 1 sets counter enables and word address 2 clears them. A 1 bit takes effect and a 0 bit has no effect. Bits 0..3 map to event counters 0..3 and bit 31 maps to the cycle counter. Reading either address returns the current enable state, masked to 0x8000000F.
- R4: Writing control bit 1 zeroes all event counters. Writing control bit 2 zeroes the cycle counter and its prescaler. Neither strobe touches the other group.
- R5: Word address 5 is a 5-bit select register. Word address 6 holds the 7-bit event number of the selected counter, and word address 7 holds its count. If the select value is above 3, both indirect addresses read as 0 and writes to them are ignored.
- R6: An event counter adds one on each clock in which three things hold: the global enable is set, the counter is enabled, and the event line named by its event number is high. Clearing the global enable freezes every counter and keeps its value.
- R7: The cycle counter sits at word address 8 and can be read and preloaded there. When it is enabled and the global enable is set, it adds one on every clock. With control bit 3 set it adds one on every 64th such clock instead.
- R8: When a counter wraps from 0xFFFFFFFF to 0, its bit in the overflow register at word address 4 is set. The bit positions are those of R3.
- R9: A 1 written to a bit of the overflow register clears that flag, and a 0 bit leaves the flag unchanged. A flag stays set until it is cleared.
- R10: The interrupt-enable register sits at word address 3 and uses the bit positions of R3. `irq` is high exactly while some overflow flag and its interrupt-enable bit are both set. The change follows one clock after the flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_req | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of the request |
| events | input | 128 | One-cycle event pulses, indexed by event number |
| irq | output | 1 | Level overflow interrupt |

## Verification
The bench aims at the edges of the count window. When the global enable is switched on and off, the counters must count every edge in between, including the edge that writes 0. A design that gated counting with the new control value would come out one count short. The divide-by-64 run must give exactly two ticks in 130 enabled clocks; an off-by-one prescaler would give one or three. The bench wraps a counter from a preloaded 0xFFFFFFFE and checks that the flag is set and the counter reads 0. It checks that write-one-to-clear leaves the other flags alone, that a flag without its interrupt enable keeps `irq` low, and that an out-of-range select neither reads nor writes any counter. A design that wrapped the select index would corrupt counter 3.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int DATA_W = 32;
  localparam int CYC_BIT = 31;

  typedef enum logic [3:0] {
    A_CTRL   = 4'd0,
    A_ENSET  = 4'd1,
    A_ENCLR  = 4'd2,
    A_INTEN  = 4'd3,
    A_FLAGS  = 4'd4,
    A_SEL    = 4'd5,
    A_ETYPE  = 4'd6,
    A_ECOUNT = 4'd7,
    A_CCOUNT = 4'd8
  } pmu_addr_e;

  localparam int CB_EN     = 0;
  localparam int CB_RSTEVT = 1;
  localparam int CB_RSTCYC = 2;
  localparam int CB_DIV    = 3;
  localparam int CB_EXP    = 4;
  localparam int CB_DBG    = 5;
endpackage

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] q,
  output logic         wrap
);
  // Precedence: strobe clear, then software load, then increment.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (clr)  q <= '0;
    else if (load) q <= load_val;
    else if (inc)  q <= q + 1'b1;
  end

  assign wrap = inc && !clr && !load && (q == {W{1'b1}});

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && !load && q == {W{1'b1}}) |=> (q == '0)); // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !clr && !load) |=> $stable(q)); // R6
endmodule

// File: rtl/pmu_prescaler.sv
module pmu_prescaler #(
  parameter int RATIO = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic div,
  output logic tick
);
  localparam int PW = (RATIO > 2) ? $clog2(RATIO) : 1;
  localparam logic [PW-1:0] LAST = PW'(RATIO - 1);

  logic [PW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (clr)         cnt <= '0;
    else if (run && div)  cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign tick = run && (!div || cnt == LAST);
endmodule

// File: rtl/pmu_event_sel.sv
module pmu_event_sel #(
  parameter int NUM_EVENTS = 128,
  parameter int EVT_W = 7
) (
  input  logic [NUM_EVENTS-1:0] events,
  input  logic [EVT_W-1:0]      evt_num,
  output logic                  hit
);
  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < NUM_EVENTS; i++)
      if (evt_num == EVT_W'(i)) hit = events[i];
  end
endmodule

// File: rtl/perf_monitor.sv
module perf_monitor
  import pmu_pkg::*;
#(
  parameter int NUM_CTR    = 4,
  parameter int CNT_W      = 32,
  parameter int EVT_W      = 7,
  parameter int NUM_EVENTS = 128,
  parameter int SEL_W      = 5,
  parameter int PRESCALE   = 64,
  parameter int ADDR_W     = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_req,
  input  logic                  reg_we,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  input  logic [NUM_EVENTS-1:0] events,
  output logic                  irq
);
  localparam int IDX_W = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1;
  localparam logic [DATA_W-1:0] CTR_MASK =
    (DATA_W'(1) << CYC_BIT) | ((DATA_W'(1) << NUM_CTR) - 1);

  function automatic logic [DATA_W-1:0] pack(input logic c, input logic [NUM_CTR-1:0] e);
    logic [DATA_W-1:0] v;
    v = '0;
    v[NUM_CTR-1:0] = e;
    v[CYC_BIT] = c;
    return v;
  endfunction

  // Register decode
  logic wr;
  logic wr_ctrl, wr_enset, wr_enclr, wr_inten, wr_flags, wr_sel, wr_etype, wr_ecount, wr_ccount;
  assign wr        = reg_req && reg_we;
  assign wr_ctrl   = wr && reg_addr == ADDR_W'(A_CTRL);
  assign wr_enset  = wr && reg_addr == ADDR_W'(A_ENSET);
  assign wr_enclr  = wr && reg_addr == ADDR_W'(A_ENCLR);
  assign wr_inten  = wr && reg_addr == ADDR_W'(A_INTEN);
  assign wr_flags  = wr && reg_addr == ADDR_W'(A_FLAGS);
  assign wr_sel    = wr && reg_addr == ADDR_W'(A_SEL);
  assign wr_etype  = wr && reg_addr == ADDR_W'(A_ETYPE);
  assign wr_ecount = wr && reg_addr == ADDR_W'(A_ECOUNT);
  assign wr_ccount = wr && reg_addr == ADDR_W'(A_CCOUNT);

  // Stored state
  logic               g_en, c_div, c_exp, c_dbg;
  logic [NUM_CTR-1:0] en_evt, ie_evt, fl_evt;
  logic               en_cyc, ie_cyc, fl_cyc;
  logic [SEL_W-1:0]   sel_q;
  logic [EVT_W-1:0]   etype_q [NUM_CTR];

  logic               sel_ok;
  logic [IDX_W-1:0]   sel_idx;
  assign sel_ok  = sel_q < SEL_W'(NUM_CTR);
  assign sel_idx = sel_q[IDX_W-1:0];

  logic rst_evt, rst_cyc;
  assign rst_evt = wr_ctrl && reg_wdata[CB_RSTEVT];
  assign rst_cyc = wr_ctrl && reg_wdata[CB_RSTCYC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g_en <= 1'b0; c_div <= 1'b0; c_exp <= 1'b0; c_dbg <= 1'b0;
      en_evt <= '0; en_cyc <= 1'b0;
      ie_evt <= '0; ie_cyc <= 1'b0;
      sel_q <= '0;
    end else begin
      if (wr_ctrl) begin
        g_en  <= reg_wdata[CB_EN];
        c_div <= reg_wdata[CB_DIV];
        c_exp <= reg_wdata[CB_EXP];
        c_dbg <= reg_wdata[CB_DBG];
      end
      if (wr_enset) begin
        en_evt <= en_evt | reg_wdata[NUM_CTR-1:0];
        en_cyc <= en_cyc | reg_wdata[CYC_BIT];
      end
      if (wr_enclr) begin
        en_evt <= en_evt & ~reg_wdata[NUM_CTR-1:0];
        en_cyc <= en_cyc & ~reg_wdata[CYC_BIT];
      end
      if (wr_inten) begin
        ie_evt <= reg_wdata[NUM_CTR-1:0];
        ie_cyc <= reg_wdata[CYC_BIT];
      end
      if (wr_sel) sel_q <= reg_wdata[SEL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CTR; i++) etype_q[i] <= '0;
    end else if (wr_etype && sel_ok) begin
      for (int i = 0; i < NUM_CTR; i++)
        if (sel_idx == IDX_W'(i)) etype_q[i] <= reg_wdata[EVT_W-1:0];
    end
  end

  // Event counters
  logic [CNT_W-1:0]   evt_cnt [NUM_CTR];
  logic [NUM_CTR-1:0] evt_wrap;
  logic [NUM_CTR-1:0] evt_hit;

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_evt
    pmu_event_sel #(.NUM_EVENTS(NUM_EVENTS), .EVT_W(EVT_W)) u_sel (
      .events (events),
      .evt_num(etype_q[g]),
      .hit    (evt_hit[g])
    );
    pmu_counter #(.W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (rst_evt),
      .load    (wr_ecount && sel_ok && sel_idx == IDX_W'(g)),
      .load_val(reg_wdata[CNT_W-1:0]),
      .inc     (g_en && en_evt[g] && evt_hit[g]),
      .q       (evt_cnt[g]),
      .wrap    (evt_wrap[g])
    );
  end

  // Cycle counter
  logic             cyc_tick, cyc_wrap;
  logic [CNT_W-1:0] cyc_cnt;

  pmu_prescaler #(.RATIO(PRESCALE)) u_presc (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (rst_cyc),
    .run  (g_en && en_cyc),
    .div  (c_div),
    .tick (cyc_tick)
  );

  pmu_counter #(.W(CNT_W)) u_cyc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (rst_cyc),
    .load    (wr_ccount),
    .load_val(reg_wdata[CNT_W-1:0]),
    .inc     (cyc_tick),
    .q       (cyc_cnt),
    .wrap    (cyc_wrap)
  );

  // Overflow flags: a new wrap wins over a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_evt <= '0;
      fl_cyc <= 1'b0;
    end else begin
      fl_evt <= (fl_evt & ~(wr_flags ? reg_wdata[NUM_CTR-1:0] : '0)) | evt_wrap;
      fl_cyc <= (fl_cyc & ~(wr_flags && reg_wdata[CYC_BIT])) | cyc_wrap;
    end
  end

  assign irq = |(pack(fl_cyc, fl_evt) & pack(ie_cyc, ie_evt));

  // Read mux
  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      ADDR_W'(A_CTRL): begin
        reg_rdata[CB_EN]  = g_en;
        reg_rdata[CB_DIV] = c_div;
        reg_rdata[CB_EXP] = c_exp;
        reg_rdata[CB_DBG] = c_dbg;
      end
      ADDR_W'(A_ENSET), ADDR_W'(A_ENCLR): reg_rdata = pack(en_cyc, en_evt);
      ADDR_W'(A_INTEN):  reg_rdata = pack(ie_cyc, ie_evt);
      ADDR_W'(A_FLAGS):  reg_rdata = pack(fl_cyc, fl_evt);
      ADDR_W'(A_SEL):    reg_rdata[SEL_W-1:0] = sel_q;
      ADDR_W'(A_ETYPE):  if (sel_ok) reg_rdata[EVT_W-1:0] = etype_q[sel_idx];
      ADDR_W'(A_ECOUNT): if (sel_ok) reg_rdata[CNT_W-1:0] = evt_cnt[sel_idx];
      ADDR_W'(A_CCOUNT): reg_rdata[CNT_W-1:0] = cyc_cnt;
      default:           reg_rdata = '0;
    endcase
  end

  AST_ENSET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_enset |=> ((pack(en_cyc, en_evt) & $past(reg_wdata & CTR_MASK)) == $past(reg_wdata & CTR_MASK))); // R3
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_flags |=> (($past(pack(fl_cyc, fl_evt)) & ~pack(fl_cyc, fl_evt)) == '0)); // R9
  AST_STROBE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(A_CTRL)) |-> (reg_rdata[CB_RSTCYC:CB_RSTEVT] == 2'b00)); // R2
  AST_BAD_SEL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_ok && (reg_addr == ADDR_W'(A_ECOUNT) || reg_addr == ADDR_W'(A_ETYPE))) |-> (reg_rdata == '0)); // R5
endmodule

// File: tb/perf_monitor_bench.sv
module perf_monitor_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_req = 1'b0;
  logic         reg_we = 1'b0;
  logic [3:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic [127:0] events = '0;
  logic         irq;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  perf_monitor u_perf_monitor (
    .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .events(events), .irq(irq)
  );

  localparam logic [3:0] CTRL = 0, ENSET = 1, ENCLR = 2, INTEN = 3, FLAGS = 4,
                         SEL = 5, ETYPE = 6, ECOUNT = 7, CCOUNT = 8;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_req = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1 reg_req = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_req = 1'b1; reg_we = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
    reg_req = 1'b0;
  endtask

  task automatic pulse(input int ev, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); events = '0; events[ev] = 1'b1;
      @(negedge clk); events = '0;
    end
  endtask

  task automatic clean();
    wr(CTRL, 32'h6);
    wr(ENCLR, 32'hFFFF_FFFF);
    wr(FLAGS, 32'hFFFF_FFFF);
    wr(INTEN, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(CTRL, v);   chk("R1 ctrl", v, 0);
    rd(ENSET, v);  chk("R1 enable", v, 0);
    rd(FLAGS, v);  chk("R1 flags", v, 0);
    rd(CCOUNT, v); chk("R1 cycles", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_ctrl();
    logic [31:0] v;
    wr(CTRL, 32'hFFFF_FFFF);
    rd(CTRL, v); chk("R2 ctrl readback", v, 32'h39);
    wr(CTRL, 32'h0);
    rd(CTRL, v); chk("R2 ctrl cleared", v, 0);
  endtask

  task automatic t_enables();
    logic [31:0] v;
    wr(ENSET, 32'h8000_00FF);
    rd(ENSET, v); chk("R3 set mask", v, 32'h8000_000F);
    wr(ENCLR, 32'h0000_0005);
    rd(ENCLR, v); chk("R3 clear bits", v, 32'h8000_000A);
    wr(ENSET, 32'h0);
    rd(ENSET, v); chk("R3 zero write no effect", v, 32'h8000_000A);
    wr(ENCLR, 32'hFFFF_FFFF);
    rd(ENSET, v); chk("R3 all cleared", v, 0);
  endtask

  task automatic t_select();
    logic [31:0] v;
    wr(SEL, 32'hFFFF_FFFF);
    rd(SEL, v); chk("R5 select width", v, 32'h1F);
    rd(ETYPE, v); chk("R5 bad sel type", v, 0);
    wr(SEL, 2); wr(ETYPE, 32'hFF);
    rd(ETYPE, v); chk("R5 type mask", v, 32'h7F);
    wr(SEL, 7);
    wr(ECOUNT, 32'h1234); wr(ETYPE, 32'h11);
    rd(ECOUNT, v); chk("R5 bad sel count", v, 0);
    for (int i = 0; i < 4; i++) begin
      wr(SEL, i);
      rd(ECOUNT, v); chk("R5 ignored write", v, 0);
    end
    wr(SEL, 2);
    rd(ETYPE, v); chk("R5 type kept", v, 32'h7F);
  endtask

  task automatic t_events();
    logic [31:0] v;
    wr(SEL, 3); wr(ETYPE, 5);
    wr(SEL, 0); wr(ETYPE, 5);
    wr(ENSET, 32'h1);
    wr(CTRL, 32'h1);
    pulse(5, 3); pulse(6, 2);
    rd(ECOUNT, v); chk("R6 counts own event", v, 3);
    wr(CTRL, 32'h0);
    pulse(5, 2);
    rd(ECOUNT, v); chk("R6 frozen", v, 3);
    wr(SEL, 3);
    rd(ECOUNT, v); chk("R3 disabled counter idle", v, 0);
    wr(SEL, 0);
  endtask

  task automatic t_cycles();
    logic [31:0] v;
    wr(ENSET, 32'h8000_0000);
    wr(CTRL, 32'h5);
    repeat (9) @(posedge clk);
    wr(CTRL, 32'h0);
    rd(CCOUNT, v); chk("R7 every clock", v, 10);
    wr(CTRL, 32'hD);
    repeat (129) @(posedge clk);
    wr(CTRL, 32'h8);
    rd(CCOUNT, v); chk("R7 divide by 64", v, 2);
  endtask

  task automatic t_strobes();
    logic [31:0] v;
    wr(CTRL, 32'h2);
    rd(ECOUNT, v); chk("R4 event reset", v, 0);
    rd(CCOUNT, v); chk("R4 cycle untouched", v, 2);
    rd(CTRL, v);   chk("R4 strobe reads 0", v, 0);
    wr(CTRL, 32'h4);
    rd(CCOUNT, v); chk("R4 cycle reset", v, 0);
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    clean();
    wr(SEL, 1); wr(ETYPE, 9); wr(ECOUNT, 32'hFFFF_FFFE);
    wr(INTEN, 32'h2); wr(ENSET, 32'h2); wr(CTRL, 32'h1);
    pulse(9, 1);
    rd(FLAGS, v); chk("R8 no early flag", v, 0);
    pulse(9, 1);
    rd(ECOUNT, v); chk("R8 wrapped to zero", v, 0);
    rd(FLAGS, v);  chk("R8 flag set", v, 32'h2);
    chk("R10 irq raised", {31'b0, irq}, 1);
    wr(SEL, 2); wr(ETYPE, 10); wr(ECOUNT, 32'hFFFF_FFFF); wr(ENSET, 32'h4);
    pulse(10, 1);
    rd(FLAGS, v); chk("R8 second flag", v, 32'h6);
    wr(FLAGS, 32'h2);
    rd(FLAGS, v); chk("R9 w1c one bit", v, 32'h4);
    chk("R10 masked flag no irq", {31'b0, irq}, 0);
    wr(INTEN, 32'h6);
    chk("R10 irq on enable", {31'b0, irq}, 1);
    wr(FLAGS, 32'hFFFF_FFFF);
    rd(FLAGS, v); chk("R9 all cleared", v, 0);
    chk("R10 irq drops", {31'b0, irq}, 0);
  endtask

  task automatic t_cyc_overflow();
    logic [31:0] v;
    clean();
    wr(CCOUNT, 32'hFFFF_FFFF);
    wr(INTEN, 32'h8000_0000);
    wr(ENSET, 32'h8000_0000);
    wr(CTRL, 32'h1);
    wr(CTRL, 32'h0);
    rd(CCOUNT, v); chk("R8 cycle wrap", v, 0);
    rd(FLAGS, v);  chk("R8 cycle flag bit31", v, 32'h8000_0000);
    chk("R10 cycle irq", {31'b0, irq}, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_ctrl();
    t_enables();
    t_select();
    t_events();
    t_cycles();
    t_strobes();
    t_overflow();
    t_cyc_overflow();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule